// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of `N` bits over several clock cycles. Each cycle it recodes a three-bit window of the multiplier into a digit in {-2, -1, 0, +1, +2}, adds that multiple of the multiplicand to a partial-product accumulator, and shifts the accumulator/multiplier pair right by two places. The scan starts at the least significant multiplier bit. A zero is appended below that bit when the operand is loaded. After `N/2` such steps, one final one-place right shift lines up the result.

The operands can be read as fractions with `N-1` fraction bits. The 2N-bit product then carries `2N-2` fraction bits. Read as integers, the output bits are exactly the signed integer product. A caller pulses `start` with both operands while the block is idle. `busy` stays high while the computation runs. `done` pulses for one cycle when `product` is valid, and the product holds until the next accepted start.

Top module: `booth4_seq_mul`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: For any operands a and b, the `product` shown when `done` is high equals the signed product a*b as a 2N-bit two's-complement value. This holds for the digit windows 001/010 (+X), 011 (+2X), 100 (-2X), 101/110 (-X) and 000/111 (0), read with the most significant window bit on the left.
- R3: A `start` accepted at a clock edge raises `busy` after that edge. `busy` stays high for exactly N/2+1 cycles. `done` is high in the cycle right after the (N/2+1)th edge that follows the accepting edge.
- R4: `done` is high for exactly one cycle per accepted start, and `busy` is low while `done` is high.
- R5: A `start` pulse while `busy` is high is ignored. The running operation finishes at its original time with the result of the original operands.
- R6: While idle with `start` low, `product` stays unchanged, whatever values the operand inputs take.
- R7: The most negative value times itself gives +2^(2N-2), which is 16'h4000 for N = 8. The most negative value times the most positive value is also exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | N | Signed multiplicand, sampled on the accepted start |
| mplier | input | N | Signed multiplier, sampled on the accepted start |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2N | Signed product |

## Verification
A wrong digit decode or a wrong sign extension in the accumulator shows up only as a wrong `product` value. It appears in the `done` cycle, N/2+2 cycles after the start. It is caught by operands whose windows exercise every digit, and by the most negative operand, where the ±2X multiple needs the guard bits. A wrong step counter shows up first as `done` arriving on the wrong cycle. It then usually also shows up as a mis-aligned product. A start that leaks in while busy changes the operands partway through, and the final product shows it.

// File: rtl/booth4_seq_mul.sv
module booth4_seq_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int STEPS = N / 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int AW    = N + 2;

  logic [AW-1:0] acc;
  logic [N:0]    mreg;
  logic [N-1:0]  xreg;
  logic [CW-1:0] cnt;

  logic [AW-1:0] xext, mult, addend, sum;
  logic          neg;
  logic [2:0]    win;
  logic          last;

  assign xext = {{2{xreg[N-1]}}, xreg};
  assign win  = mreg[2:0];
  assign last = (cnt == CW'(STEPS));

  always_comb begin
    mult = '0;
    neg  = 1'b0;
    case (win)
      3'b001, 3'b010: mult = xext;
      3'b011:         mult = xext << 1;
      3'b100: begin   mult = xext << 1; neg = 1'b1; end
      3'b101, 3'b110: begin mult = xext; neg = 1'b1; end
      default:        mult = '0;
    endcase
  end

  assign addend = neg ? ~mult : mult;
  assign sum    = acc + addend + {{(AW-1){1'b0}}, neg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      mreg <= '0;
      xreg <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc  <= '0;
          mreg <= {mplier, 1'b0};
          xreg <= mcand;
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else if (!last) begin
        acc  <= {{2{sum[AW-1]}}, sum[AW-1:2]};
        mreg <= {sum[1:0], mreg[N:2]};
        cnt  <= cnt + 1'b1;
      end else begin
        acc  <= {acc[AW-1], acc[AW-1:1]};
        mreg <= {acc[0], mreg[N:1]};
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign product = {acc[N-2:0], mreg};
endmodule

// File: rtl/booth4_seq_mul_chk.sv
module booth4_seq_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int STEPS = N / 2;
  logic [7:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (!busy && start) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 8'(STEPS + 1) && done));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && bcnt < 8'(STEPS)) |=> busy);
endmodule

bind booth4_seq_mul booth4_seq_mul_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_booth4_seq_mul.sv
module tb_booth4_seq_mul;
  localparam int N = 8;
  localparam int LAT = N / 2 + 2;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*N-1:0] product;

  int checks = 0, fails = 0, cycles = 0;

  localparam logic [N-1:0] TA [NV] = '{8'h03, 8'hFF, 8'h80, 8'h7F, 8'h80,
                                       8'h00, 8'h01, 8'hFD, 8'h55, 8'h64};
  localparam logic [N-1:0] TB [NV] = '{8'h05, 8'hFF, 8'h80, 8'h7F, 8'h7F,
                                       8'hB3, 8'h80, 8'h07, 8'hAA, 8'hCE};
  localparam logic [2*N-1:0] TP [NV] = '{16'h000F, 16'h0001, 16'h4000, 16'h3F01, 16'hC080,
                                         16'h0000, 16'hFF80, 16'hFFEB, 16'hE372, 16'hEC78};

  booth4_seq_mul #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic mul(input logic [N-1:0] a, input logic [N-1:0] b,
                     input logic [2*N-1:0] exp, input string req, input bit poke);
    int k;
    logic [2*N-1:0] held;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 50) begin
      if (poke && k == 2) begin
        mcand = ~a; mplier = b ^ 8'h5A; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == LAT, "R3 latency", k, LAT);
    chk(!busy, "R4 busy low with done", busy, 0);
    chk(product == exp, req, product, exp);
    held = product;
    mcand = 8'hC3; mplier = 8'h3C;
    @(negedge clk);
    chk(!done, "R4 done single cycle", done, 0);
    repeat (2) @(negedge clk);
    chk(product == held, "R6 product held", product, held);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !done && product == '0, "R1 in reset", {busy, done, product}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && product == '0, "R1 after reset", {busy, done, product}, 0);

    for (int i = 0; i < NV; i++)
      mul(TA[i], TB[i], TP[i], "R2 table product", 1'b0);

    mul(8'h80, 8'h80, 16'h4000, "R7 most negative squared", 1'b0);
    mul(8'h80, 8'h7F, 16'hC080, "R7 min times max", 1'b0);
    mul(8'h27, 8'h66, 16'(39 * 102), "R5 start while busy ignored", 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] a, b;
      logic signed [2*N-1:0] e;
      a = N'($urandom);
      b = N'($urandom);
      e = $signed(a) * $signed(b);
      mul(a, b, e, "R2 random product", 1'b0);
    end

    finish_run();
  end
endmodule